// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is a bus master that places incoming frames into a ring of sixteen receive descriptors held in shared memory. When the controller is running, the engine walks the ring, looking for a descriptor that software has handed to it. Once it finds one, it reads that descriptor's buffer address and parks, signalling that it can take a frame. A frame offered on the byte stream is then copied byte by byte into the buffer. After the last byte, the engine writes the stored byte count and then the completion status. It then advances its ring pointer and pulses a receive event for the interrupt logic.

If no descriptor is available, or the controller is stopped, an offered frame is drained from the stream and discarded without touching memory. The memory side is a single request/acknowledge port that carries byte and 16-bit word accesses.

Top module: `rx_ring_engine`

## Requirements
- R1: The ring has 16 descriptors of 8 bytes. Descriptor i starts at `ring_base + 8*i` and holds the buffer address bits 15:0 as a word at offset 0, the status byte at offset 2, buffer address bits 23:16 at offset 3, and the received byte count as a word at offset 6. Index arithmetic is modulo 16.
- R2: A descriptor is usable only when its status byte equals exactly 0x80. Any other value, including 0x81, is passed over.
- R3: A search examines 15 entries, from the ring pointer forward with wraparound. The entry just behind the pointer (pointer-1 mod 16) is never examined.
- R4: For a stored frame, byte k goes to buffer address + k and the byte count is written as a word at offset 6. The status byte 0x03 is written last, as the final memory write of that frame.
- R5: After a stored frame, the ring pointer advances by exactly one modulo 16, whichever entry was used, and `rint` pulses high for one cycle, once per stored frame.
- R6: While `stopped` is high, the engine makes no memory writes, `rx_ready` is low, and offered frames are consumed and discarded.
- R7: `rx_ready` is high only when `stopped` is low and a usable descriptor has been found and not yet filled.
- R8: If no usable descriptor exists in the search window, an offered frame is consumed and discarded. No memory is written and no `rint` pulse occurs.
- R9: Only the first 1544 bytes of a longer frame are stored, and the count written is then 1544. No byte is written at buffer offset 1544 or above.
- R10: `mem_req`, with its address, direction, size and write data, holds steady until `mem_ack`. A word access carries its low byte at the address and its high byte at the address + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stopped | input | 1 | Controller stopped; no frame accepted |
| ring_base | input | 24 | Byte address of descriptor 0 |
| frm_valid | input | 1 | Frame byte valid |
| frm_data | input | 8 | Frame byte |
| frm_last | input | 1 | Current byte ends the frame |
| frm_ready | output | 1 | Byte accepted at this clock |
| rx_ready | output | 1 | A usable descriptor is held and the engine can store a frame |
| rint | output | 1 | One-cycle receive event after a frame is stored |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | 1 = 16-bit access, 0 = byte access |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 16 | Write data (byte in bits 7:0) |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 16 | Read data |

## Verification
The bench aims at the search window. It places the only usable entry just behind the pointer and expects a drop; an engine that examined all sixteen entries would store the frame there. It puts 0x81 next to a 0x80 entry, so a design that tested only the owner bit would fill the wrong descriptor. It also relies on the pointer stepping by one rather than to the hit entry plus one: with entries 0 and 2 free and the pointer at 1, a wrong step would pick entry 0. A 1600-byte frame catches a missing length cap, either as a wrong count or as a stray byte past offset 1543.

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
  parameter int AW        = 24,
  parameter int RING_LOG  = 4,
  parameter int BUF_BYTES = 1544
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stopped,
  input  logic [AW-1:0] ring_base,
  input  logic          frm_valid,
  input  logic [7:0]    frm_data,
  input  logic          frm_last,
  output logic          frm_ready,
  output logic          rx_ready,
  output logic          rint,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_word,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [15:0]   mem_rdata
);
  localparam int RING_N = 1 << RING_LOG;
  localparam int LW     = $clog2(BUF_BYTES + 1);
  localparam int HW     = AW - 16;

  typedef enum logic [3:0] {
    S_IDLE, S_PROBE, S_ADRLO, S_ADRHI, S_PARK,
    S_STORE, S_COUNT, S_STAT, S_MISS, S_DROP
  } state_t;

  state_t              st;
  logic [RING_LOG-1:0] ptr, idx, tries;
  logic [AW-1:0]       bufa;
  logic [LW-1:0]       len;
  logic                issued;
  logic [AW-1:0]       desc_addr;

  assign desc_addr = ring_base + AW'({idx, 3'b000});
  assign frm_ready = (st == S_DROP) || (st == S_STORE && !mem_req);
  assign rx_ready  = (st == S_PARK) && !stopped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr <= '0; idx <= '0; tries <= '0; bufa <= '0; len <= '0;
      issued <= 1'b0; rint <= 1'b0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_word <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      rint <= 1'b0;
      if (mem_ack) mem_req <= 1'b0;
      case (st)
        S_IDLE:
          if (stopped) begin
            if (frm_valid) st <= S_DROP;
          end else begin
            idx <= ptr; tries <= '0; st <= S_PROBE;
          end
        S_PROBE:
          if (!mem_req) begin
            mem_req <= 1'b1; mem_we <= 1'b0; mem_word <= 1'b0; mem_addr <= desc_addr + AW'(2);
          end else if (mem_ack) begin
            if (mem_rdata[7:0] == 8'h80) st <= S_ADRLO;
            else if (tries == RING_LOG'(RING_N - 2)) st <= S_MISS;
            else begin
              idx <= idx + 1'b1; tries <= tries + 1'b1;
            end
          end
        S_ADRLO:
          if (!mem_req) begin
            mem_req <= 1'b1; mem_we <= 1'b0; mem_word <= 1'b1; mem_addr <= desc_addr;
          end else if (mem_ack) begin
            bufa[15:0] <= mem_rdata; st <= S_ADRHI;
          end
        S_ADRHI:
          if (!mem_req) begin
            mem_req <= 1'b1; mem_we <= 1'b0; mem_word <= 1'b0; mem_addr <= desc_addr + AW'(3);
          end else if (mem_ack) begin
            bufa[AW-1:16] <= mem_rdata[HW-1:0]; st <= S_PARK;
          end
        S_PARK:
          if (stopped) st <= S_IDLE;
          else if (frm_valid) begin
            len <= '0; st <= S_STORE;
          end
        S_STORE:
          if (frm_valid && frm_ready) begin
            if (len < LW'(BUF_BYTES)) begin
              mem_req <= 1'b1; mem_we <= 1'b1; mem_word <= 1'b0;
              mem_addr <= bufa + AW'(len); mem_wdata <= {8'h00, frm_data};
              len <= len + 1'b1;
            end
            if (frm_last) st <= S_COUNT;
          end
        S_COUNT:
          if (!mem_req && !issued) begin
            mem_req <= 1'b1; mem_we <= 1'b1; mem_word <= 1'b1;
            mem_addr <= desc_addr + AW'(6); mem_wdata <= 16'(len); issued <= 1'b1;
          end else if (mem_ack && issued) begin
            issued <= 1'b0; st <= S_STAT;
          end
        S_STAT:
          if (!mem_req && !issued) begin
            mem_req <= 1'b1; mem_we <= 1'b1; mem_word <= 1'b0;
            mem_addr <= desc_addr + AW'(2); mem_wdata <= 16'h0003; issued <= 1'b1;
          end else if (mem_ack && issued) begin
            issued <= 1'b0; ptr <= ptr + 1'b1; rint <= 1'b1; st <= S_IDLE;
          end
        S_MISS:
          st <= frm_valid ? S_DROP : S_IDLE;
        S_DROP:
          if (frm_valid && frm_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_word) && $stable(mem_wdata));

  p_quiet_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stopped && st == S_IDLE && !mem_req |=> !mem_req);

  p_status_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rint |-> $past(mem_ack && mem_we && !mem_word && mem_wdata[7:0] == 8'h03));

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rint |-> ptr == $past(ptr) + 1'b1);

  p_len_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    len <= LW'(BUF_BYTES));

  p_buf_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_STORE && mem_req && mem_we |-> mem_addr - bufa < AW'(BUF_BYTES));
endmodule

// File: tb/test_rx_ring_engine.sv
module test_rx_ring_engine;
  logic        clk = 1'b0, rst_n = 1'b0, stopped = 1'b1;
  logic [23:0] ring_base = 24'h001000;
  logic        frm_valid = 1'b0, frm_last = 1'b0;
  logic [7:0]  frm_data = 8'h00;
  logic        frm_ready, rx_ready, rint;
  logic        mem_req, mem_we, mem_word, mem_ack;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  int errors = 0, checks = 0;
  int wr_count = 0, rint_count = 0, cycles = 0;
  int mptr = 0;
  bit done = 0;
  logic [7:0] mem [int];

  always #4 clk = ~clk;

  rx_ring_engine i_rx_ring_engine (
    .clk(clk), .rst_n(rst_n), .stopped(stopped), .ring_base(ring_base),
    .frm_valid(frm_valid), .frm_data(frm_data), .frm_last(frm_last), .frm_ready(frm_ready),
    .rx_ready(rx_ready), .rint(rint),
    .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  function automatic logic [7:0] rd(int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  function automatic int desc(int i);
    return 32'h1000 + 8 * i;
  endfunction

  function automatic int bufaddr(int i);
    return 32'h010000 + i * 32'h800;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        wr_count++;
        mem[int'(mem_addr)] = mem_wdata[7:0];
        if (mem_word) mem[int'(mem_addr) + 1] = mem_wdata[15:8];
      end else begin
        mem_rdata <= mem_word ? {rd(int'(mem_addr) + 1), rd(int'(mem_addr))}
                              : {8'h00, rd(int'(mem_addr))};
      end
    end else mem_ack <= 1'b0;
  end

  logic        p_req, p_ack, p_we;
  logic [23:0] p_addr;
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (rint) rint_count++;
      if (stopped && mem_req && mem_we) check(0, "R6 write while stopped", 1, 0);
      if (rx_ready) check(!stopped, "R7 ready while stopped", stopped, 0);
      if (p_req && !p_ack)
        check(mem_req && mem_addr == p_addr && mem_we == p_we, "R10 request hold", mem_addr, p_addr);
    end
    p_req = mem_req; p_ack = mem_ack; p_we = mem_we; p_addr = mem_addr;
  end

  task automatic init_ring();
    for (int i = 0; i < 16; i++) begin
      mem[desc(i)]     = bufaddr(i) & 8'hff;
      mem[desc(i) + 1] = (bufaddr(i) >> 8) & 8'hff;
      mem[desc(i) + 2] = 8'h00;
      mem[desc(i) + 3] = (bufaddr(i) >> 16) & 8'hff;
      mem[desc(i) + 6] = 8'h00;
      mem[desc(i) + 7] = 8'h00;
    end
  endtask

  task automatic set_stat(int i, logic [7:0] v);
    mem[desc(i) + 2] = v;
  endtask

  task automatic pause_and(input int dummy);
    stopped = 1'b1;
    repeat (60) @(negedge clk);
  endtask

  task automatic send_frame(int n, int seed);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      frm_valid = 1'b1; frm_data = 8'((seed + 7 * k) & 8'hff); frm_last = (k == n - 1);
      while (!frm_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    frm_valid = 1'b0; frm_last = 1'b0;
  endtask

  function automatic int expect_hit();
    for (int k = 0; k < 15; k++) begin
      int j = (mptr + k) % 16;
      if (rd(desc(j) + 2) == 8'h80) return j;
    end
    return -1;
  endfunction

  task automatic run_frame(int n, int seed, string tag);
    int exp, w0, r0, wait_n, stored;
    logic [7:0] snap [16];
    exp = expect_hit();
    w0 = wr_count; r0 = rint_count;
    for (int i = 0; i < 16; i++) snap[i] = rd(desc(i) + 2);
    if (exp >= 0) begin
      wait_n = 0;
      while (!rx_ready && wait_n < 2000) begin @(negedge clk); wait_n++; end
      check(rx_ready, {tag, " R7 ready before frame"}, rx_ready, 1);
    end
    send_frame(n, seed);
    wait_n = 0;
    while (rint_count == r0 && wait_n < ((exp >= 0) ? 8000 : 300)) begin @(negedge clk); wait_n++; end
    repeat (4) @(negedge clk);
    if (exp >= 0) begin
      stored = (n > 1544) ? 1544 : n;
      check(rint_count == r0 + 1, {tag, " R5 one rint"}, rint_count - r0, 1);
      check(rd(desc(exp) + 2) == 8'h03, {tag, " R4 status"}, rd(desc(exp) + 2), 3);
      check({rd(desc(exp) + 7), rd(desc(exp) + 6)} == 16'(stored), {tag, " R4 R9 count"},
            {rd(desc(exp) + 7), rd(desc(exp) + 6)}, stored);
      begin
        int bad = 0, first = -1;
        for (int k = 0; k < stored; k++)
          if (rd(bufaddr(exp) + k) != 8'((seed + 7 * k) & 8'hff)) begin
            bad++; if (first < 0) first = k;
          end
        check(bad == 0, {tag, " R4 buffer bytes"}, first, -1);
      end
      for (int i = 0; i < 16; i++)
        if (i != exp) check(rd(desc(i) + 2) == snap[i], {tag, " R2 other status kept"}, rd(desc(i) + 2), snap[i]);
      mptr = (mptr + 1) % 16;
    end else begin
      check(wr_count == w0, {tag, " R8 no write on drop"}, wr_count - w0, 0);
      check(rint_count == r0, {tag, " R8 no rint on drop"}, rint_count - r0, 0);
      for (int i = 0; i < 16; i++)
        check(rd(desc(i) + 2) == snap[i], {tag, " R8 status kept"}, rd(desc(i) + 2), snap[i]);
    end
  endtask

  initial begin
    while (cycles < 200000 && !done) @(negedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    init_ring();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rx_ready && !mem_req && !rint && !frm_ready, "R6 reset state",
          {rx_ready, mem_req, rint, frm_ready}, 0);

    begin
      int w0 = wr_count, r0 = rint_count;
      set_stat(6, 8'h80);
      send_frame(20, 8'h11);
      repeat (40) @(negedge clk);
      check(wr_count == w0 && rint_count == r0, "R6 frame while stopped", wr_count - w0, 0);
      check(!rx_ready, "R6 ready low while stopped", rx_ready, 0);
      set_stat(6, 8'h00);
    end

    stopped = 1'b0;
    repeat (200) @(negedge clk);
    check(!rx_ready, "R7 no usable entry", rx_ready, 0);
    run_frame(12, 8'h20, "empty ring");

    pause_and(0); set_stat(3, 8'h80); stopped = 1'b0;
    run_frame(10, 8'h30, "R1 first hit");

    pause_and(0); set_stat(0, 8'h80); set_stat(2, 8'h80); stopped = 1'b0;
    run_frame(16, 8'h40, "R5 pointer step");
    check(rd(desc(0) + 2) == 8'h80, "R5 entry 0 untouched", rd(desc(0) + 2), 8'h80);

    pause_and(0); set_stat(0, 8'h00); set_stat(1, 8'h80); set_stat(4, 8'h81); stopped = 1'b0;
    run_frame(8, 8'h50, "R3 entry behind pointer");
    check(rd(desc(1) + 2) == 8'h80, "R3 behind entry kept", rd(desc(1) + 2), 8'h80);

    pause_and(0); set_stat(5, 8'h80); stopped = 1'b0;
    run_frame(30, 8'h60, "R2 exact match");
    check(rd(desc(4) + 2) == 8'h81, "R2 0x81 skipped", rd(desc(4) + 2), 8'h81);

    run_frame(1, 8'h70, "R3 wrap single byte");

    pause_and(0); set_stat(7, 8'h80); mem[bufaddr(7) + 1544] = 8'hEE; stopped = 1'b0;
    run_frame(1600, 8'h80, "R9 long frame");
    check(rd(bufaddr(7) + 1544) == 8'hEE, "R9 no byte past cap", rd(bufaddr(7) + 1544), 8'hEE);

    pause_and(0); set_stat(9, 8'h80); stopped = 1'b0;
    run_frame(60, 8'h90, "R4 short frame");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule